// File: doc/BRIEF.md
# Stop-Mode Wakeup Sequencer

This block takes a processor core out of its low-power stop state. While running, a stop request parks the block in STOP and drops the main clock enable. If the PLL variant is chosen, the PLL enable drops as well. A PLL stop is only accepted when the selected settling time is one of the two long settings. Otherwise the request is refused, a sticky flag is raised, and the block keeps running.

While stopped, the block watches a set of external interrupt sources, each with a 3-bit priority level where a smaller number is more urgent. Only a request more urgent than the weakest level ends the stop. It first re-enables both clocks and runs a single settling countdown that covers the oscillator and the PLL together. Requests that arrive during the countdown are remembered, but they do not restart it. After the countdown, the block spends one cycle deciding. It then emits a one-cycle pulse that either tells the core to take the interrupt or to continue with the instruction after the stop. It takes the interrupt only if the global enable is set and the most urgent remembered level is numerically below the mask level.

Top module: `stop_wake_seq`

## Requirements
- R1: After reset the block is running: main_clk_en and pll_en are 1, stab_busy, resume_pulse, branch_pulse and pll_refused are 0.
- R2: A stop_req while running is accepted on the next clock edge: main_clk_en goes to 0 and stays 0 while stopped.
- R3: In a PLL stop (pll_sel=1 at the request) both main_clk_en and pll_en are 0. In a plain stop (pll_sel=0), pll_en stays 1.
- R4: A stop_req with pll_sel=1 and wait_sel of 2'b00 or 2'b01 is refused. pll_refused becomes 1 and stays 1 until reset, and the block keeps running with both enables at 1.
- R5: While stopped, requests whose level is 3'd7 (the weakest) have no effect: the block stays stopped with clocks off and stab_busy 0.
- R6: A request with level below 3'd7 while stopped ends the stop. Both enables return to 1, and stab_busy is 1 for exactly the settling length.
- R7: The settling length is 2^(BASE_EXP + STEP_EXP*wait_sel) cycles, using the wait_sel captured at the accepted stop request. With the defaults BASE_EXP=10 and STEP_EXP=2, the values 00/01/10/11 give 2^10/2^12/2^14/2^16.
- R8: After the countdown there is exactly one decision cycle with no pulse. The next cycle carries a single one-cycle pulse: branch_pulse if ie_flag=1 and the latched best level is less than mask_lvl, otherwise resume_pulse. The two pulses never coincide.
- R9: Requests during the countdown update the latched best level (the minimum seen) without restarting the countdown.
- R10: stop_req has no effect unless the block is running. A refusable request while stopped neither sets pll_refused nor changes the clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Request to enter stop (one cycle) |
| pll_sel | input | 1 | Select PLL variant of stop |
| wait_sel | input | 2 | Settling-length select |
| irq_req | input | SRC_N | Per-source interrupt request |
| irq_lvl | input | SRC_N*LVL_W | Per-source priority level, source i in bits [i*LVL_W +: LVL_W] |
| ie_flag | input | 1 | Global interrupt enable |
| mask_lvl | input | LVL_W | Current mask level |
| main_clk_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| stab_busy | output | 1 | Settling countdown in progress |
| resume_pulse | output | 1 | Continue at next instruction (one cycle) |
| branch_pulse | output | 1 | Take interrupt now (one cycle) |
| pll_refused | output | 1 | Sticky: a PLL stop was refused |

## Verification
The bench builds the block with BASE_EXP=2 and STEP_EXP=2. This turns the four settling lengths into 4, 16, 64 and 256 cycles, so every wait_sel value, including both PLL-legal ones, can be measured cycle by cycle in a short run. It keeps the defaults of four sources and 3-bit levels. That makes the weakest level, the mask comparison at its edges, and the minimum over several sources during the countdown all reachable.

// File: rtl/swq_pkg.sv
`timescale 1ns/1ps
package swq_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_STAB   = 2'd2,
    ST_DECIDE = 2'd3
  } swq_state_e;

  // settling length in cycles for a select value
  function automatic logic [31:0] settle_cycles(input logic [1:0] sel,
                                                input int base_exp,
                                                input int step_exp);
    return 32'd1 << (base_exp + step_exp * int'(sel));
  endfunction

  // true when a latched level may be taken under the enable and mask
  function automatic logic level_taken(input logic ie,
                                       input logic [7:0] lvl,
                                       input logic [7:0] mask);
    return ie && (lvl < mask);
  endfunction

  // a PLL stop needs one of the two long settling selects
  function automatic logic pll_select_ok(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/swq_prio.sv
`timescale 1ns/1ps
module swq_prio #(
  parameter int SRC_N = 4,
  parameter int LVL_W = 3
) (
  input  logic [SRC_N-1:0]       req,
  input  logic [SRC_N*LVL_W-1:0] lvl,
  output logic                   any_req,
  output logic [LVL_W-1:0]       best_lvl
);
  localparam logic [LVL_W-1:0] WEAKEST = {LVL_W{1'b1}};

  logic [LVL_W-1:0] stage [SRC_N+1];
  logic [SRC_N:0]   seen;

  assign stage[0] = WEAKEST;
  assign seen[0]  = 1'b0;

  generate
    for (genvar i = 0; i < SRC_N; i++) begin : g_src
      logic [LVL_W-1:0] cand;
      assign cand = lvl[i*LVL_W +: LVL_W];
      assign stage[i+1] = (req[i] && cand < stage[i]) ? cand : stage[i];
      assign seen[i+1]  = seen[i] | req[i];
    end
  endgenerate

  assign any_req  = seen[SRC_N];
  assign best_lvl = stage[SRC_N];
endmodule

// File: rtl/swq_timer.sv
`timescale 1ns/1ps
module swq_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run && (cnt_q == '0);
endmodule

// File: rtl/stop_wake_seq.sv
`timescale 1ns/1ps
module stop_wake_seq #(
  parameter int SRC_N    = 4,
  parameter int LVL_W    = 3,
  parameter int BASE_EXP = 10,
  parameter int STEP_EXP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stop_req,
  input  logic                   pll_sel,
  input  logic [1:0]             wait_sel,
  input  logic [SRC_N-1:0]       irq_req,
  input  logic [SRC_N*LVL_W-1:0] irq_lvl,
  input  logic                   ie_flag,
  input  logic [LVL_W-1:0]       mask_lvl,
  output logic                   main_clk_en,
  output logic                   pll_en,
  output logic                   stab_busy,
  output logic                   resume_pulse,
  output logic                   branch_pulse,
  output logic                   pll_refused
);
  import swq_pkg::*;

  localparam int MAX_EXP = BASE_EXP + 3 * STEP_EXP;
  localparam int CNT_W   = MAX_EXP + 1;
  localparam logic [LVL_W-1:0] WEAKEST = {LVL_W{1'b1}};

  swq_state_e       st_q;
  logic             pll_mode_q;
  logic [1:0]       wsel_q;
  logic             refused_q;
  logic [LVL_W-1:0] best_q;
  logic             resume_q, branch_q;

  // named internal events
  logic             any_req;
  logic [LVL_W-1:0] best_lvl;
  logic             wake_ev;
  logic             refuse_ev;
  logic             enter_ev;
  logic             tmr_done;
  logic             take_irq;
  logic [CNT_W-1:0] load_val;

  swq_prio #(.SRC_N(SRC_N), .LVL_W(LVL_W)) prio_i (
    .req      (irq_req),
    .lvl      (irq_lvl),
    .any_req  (any_req),
    .best_lvl (best_lvl)
  );

  assign load_val = CNT_W'(settle_cycles(wsel_q, BASE_EXP, STEP_EXP) - 32'd1);

  swq_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_ev),
    .load_val (load_val),
    .run      (st_q == ST_STAB),
    .done     (tmr_done)
  );

  assign refuse_ev = (st_q == ST_RUN) && stop_req && pll_sel && !pll_select_ok(wait_sel);
  assign enter_ev  = (st_q == ST_RUN) && stop_req && !refuse_ev;
  assign wake_ev   = (st_q == ST_STOP) && any_req && (best_lvl < WEAKEST);
  assign take_irq  = level_taken(ie_flag, 8'(best_q), 8'(mask_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      pll_mode_q <= 1'b0;
      wsel_q     <= 2'b00;
      refused_q  <= 1'b0;
      best_q     <= WEAKEST;
      resume_q   <= 1'b0;
      branch_q   <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      branch_q <= 1'b0;
      if (refuse_ev) refused_q <= 1'b1;
      unique case (st_q)
        ST_RUN: begin
          if (enter_ev) begin
            st_q       <= ST_STOP;
            pll_mode_q <= pll_sel;
            wsel_q     <= wait_sel;
          end
        end
        ST_STOP: begin
          if (wake_ev) begin
            st_q   <= ST_STAB;
            best_q <= best_lvl;
          end
        end
        ST_STAB: begin
          if (any_req && best_lvl < best_q) best_q <= best_lvl;
          if (tmr_done) st_q <= ST_DECIDE;
        end
        ST_DECIDE: begin
          st_q     <= ST_RUN;
          branch_q <= take_irq;
          resume_q <= !take_irq;
          best_q   <= WEAKEST;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign main_clk_en  = (st_q != ST_STOP);
  assign pll_en       = !((st_q == ST_STOP) && pll_mode_q);
  assign stab_busy    = (st_q == ST_STAB);
  assign resume_pulse = resume_q;
  assign branch_pulse = branch_q;
  assign pll_refused  = refused_q;
endmodule

// File: rtl/swq_chk.sv
`timescale 1ns/1ps
module swq_chk #(
  parameter int SRC_N    = 4,
  parameter int LVL_W    = 3,
  parameter int BASE_EXP = 10,
  parameter int STEP_EXP = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stop_req,
  input logic                   pll_sel,
  input logic [1:0]             wait_sel,
  input logic [SRC_N-1:0]       irq_req,
  input logic [SRC_N*LVL_W-1:0] irq_lvl,
  input logic                   main_clk_en,
  input logic                   pll_en,
  input logic                   resume_pulse,
  input logic                   branch_pulse,
  input logic                   pll_refused,
  input swq_pkg::swq_state_e    st,
  input logic                   pll_mode,
  input logic [1:0]             wsel
);
  import swq_pkg::*;

  logic urgent;
  always_comb begin
    urgent = 1'b0;
    for (int i = 0; i < SRC_N; i++)
      if (irq_req[i] && irq_lvl[i*LVL_W +: LVL_W] != {LVL_W{1'b1}}) urgent = 1'b1;
  end

  logic [31:0] dur_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dur_q <= '0;
    else if (st == ST_STAB) dur_q <= dur_q + 32'd1;
    else dur_q <= '0;
  end

  // R4
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && stop_req && pll_sel && !wait_sel[1]) |=> (st == ST_RUN && pll_refused));

  // R4
  refuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_refused |=> pll_refused);

  // R3
  pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && pll_mode) |-> (!pll_en && !main_clk_en));

  // R5
  weak_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && !urgent) |=> (st == ST_STOP));

  // R7
  settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DECIDE) |-> (dur_q == (32'd1 << (BASE_EXP + STEP_EXP * int'(wsel)))));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_pulse && branch_pulse));

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_pulse || branch_pulse) |=> !(resume_pulse || branch_pulse));

  // R8
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_pulse || branch_pulse) |-> (st == ST_RUN && $past(st) == ST_DECIDE));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RUN && !pll_refused) |=> !pll_refused);
endmodule

bind stop_wake_seq swq_chk #(
  .SRC_N(SRC_N), .LVL_W(LVL_W), .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .pll_sel(pll_sel),
  .wait_sel(wait_sel), .irq_req(irq_req), .irq_lvl(irq_lvl),
  .main_clk_en(main_clk_en), .pll_en(pll_en), .resume_pulse(resume_pulse),
  .branch_pulse(branch_pulse), .pll_refused(pll_refused),
  .st(st_q), .pll_mode(pll_mode_q), .wsel(wsel_q)
);

// File: tb/stop_wake_seq_tb_top.sv
`timescale 1ns/1ps
module stop_wake_seq_tb_top;
  localparam int SRC_N = 4;
  localparam int LVL_W = 3;
  localparam int BASE  = 2;
  localparam int STEP  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0;
  logic pll_sel = 1'b0;
  logic [1:0] wait_sel = 2'b00;
  logic [SRC_N-1:0] irq_req = '0;
  logic [SRC_N*LVL_W-1:0] irq_lvl = '0;
  logic ie_flag = 1'b0;
  logic [LVL_W-1:0] mask_lvl = '0;
  logic main_clk_en, pll_en, stab_busy, resume_pulse, branch_pulse, pll_refused;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stop_wake_seq #(.SRC_N(SRC_N), .LVL_W(LVL_W), .BASE_EXP(BASE), .STEP_EXP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .pll_sel(pll_sel),
    .wait_sel(wait_sel), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .ie_flag(ie_flag), .mask_lvl(mask_lvl), .main_clk_en(main_clk_en),
    .pll_en(pll_en), .stab_busy(stab_busy), .resume_pulse(resume_pulse),
    .branch_pulse(branch_pulse), .pll_refused(pll_refused)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_irq(input int src, input int lvl, input bit on);
    irq_lvl[src*LVL_W +: LVL_W] = LVL_W'(lvl);
    irq_req[src] = on;
  endtask

  task automatic enter_stop(input bit pll, input logic [1:0] sel);
    pll_sel = pll; wait_sel = sel; stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
  endtask

  // measures countdown cycles after a waking request is present; returns pulse kind
  task automatic wake_and_measure(output int n, output int kind);
    tick();
    n = 0;
    while (stab_busy && n < 100000) begin n++; tick(); end
    irq_req = '0;
    // decision cycle: no pulse yet (R8)
    check(!resume_pulse && !branch_pulse, "R8 decide-cycle quiet",
          int'(resume_pulse | branch_pulse), 0);
    tick();
    kind = branch_pulse ? 2 : (resume_pulse ? 1 : 0);
    check(!(resume_pulse && branch_pulse), "R8 exclusive", int'(resume_pulse & branch_pulse), 0);
    tick();
    check(!resume_pulse && !branch_pulse, "R8 single pulse", int'(resume_pulse | branch_pulse), 0);
  endtask

  task automatic t_reset();
    check(main_clk_en && pll_en, "R1 enables", int'({main_clk_en, pll_en}), 3);
    check(!stab_busy && !resume_pulse && !branch_pulse && !pll_refused, "R1 quiet outputs",
          int'({stab_busy, resume_pulse, branch_pulse, pll_refused}), 0);
  endtask

  task automatic t_plain_stop_resume();
    int n, kind;
    enter_stop(1'b0, 2'b01);
    check(!main_clk_en, "R2 main off", int'(main_clk_en), 0);
    check(pll_en, "R3 plain stop keeps pll", int'(pll_en), 1);
    ie_flag = 1'b0; mask_lvl = 3'd7;
    set_irq(2, 3, 1'b1);
    wake_and_measure(n, kind);
    check(n == 16, "R6 R7 length sel=01", n, 16);
    check(kind == 1, "R8 resume when disabled", kind, 1);
    check(main_clk_en && pll_en, "R6 clocks back", int'({main_clk_en, pll_en}), 3);
  endtask

  task automatic t_pll_stop_branch();
    int n, kind;
    enter_stop(1'b1, 2'b10);
    check(!main_clk_en && !pll_en, "R3 pll stop both off", int'({main_clk_en, pll_en}), 0);
    check(!pll_refused, "R4 legal select accepted", int'(pll_refused), 0);
    ie_flag = 1'b1; mask_lvl = 3'd4;
    set_irq(0, 3, 1'b1);
    tick();
    check(main_clk_en && pll_en && stab_busy, "R6 wake raises enables",
          int'({main_clk_en, pll_en, stab_busy}), 7);
    n = 1;
    while (stab_busy && n < 100000) begin n++; tick(); end
    n--;
    irq_req = '0;
    check(n == 64, "R7 length sel=10", n, 64);
    tick();
    check(branch_pulse && !resume_pulse, "R8 branch 3<4", int'({branch_pulse, resume_pulse}), 2);
    tick();
  endtask

  task automatic t_mask_edge();
    int n, kind;
    enter_stop(1'b0, 2'b00);
    ie_flag = 1'b1; mask_lvl = 3'd4;
    set_irq(1, 4, 1'b1);
    wake_and_measure(n, kind);
    check(n == 4, "R7 length sel=00", n, 4);
    check(kind == 1, "R8 resume when level equals mask", kind, 1);
  endtask

  task automatic t_refuse();
    enter_stop(1'b1, 2'b01);
    check(pll_refused, "R4 refused flag", int'(pll_refused), 1);
    check(main_clk_en && pll_en && !stab_busy, "R4 still running",
          int'({main_clk_en, pll_en, stab_busy}), 6);
    repeat (3) tick();
    check(pll_refused, "R4 sticky", int'(pll_refused), 1);
  endtask

  task automatic t_weak_ignored_and_stop_idle();
    int n, kind;
    enter_stop(1'b1, 2'b11);
    set_irq(3, 7, 1'b1);
    set_irq(1, 7, 1'b1);
    repeat (10) tick();
    check(!main_clk_en && !pll_en && !stab_busy, "R5 level 7 ignored",
          int'({main_clk_en, pll_en, stab_busy}), 0);
    irq_req = '0;
    stop_req = 1'b1; pll_sel = 1'b0; wait_sel = 2'b00;
    tick();
    stop_req = 1'b0;
    tick();
    check(!main_clk_en && !pll_en, "R10 stop_req in stop no effect",
          int'({main_clk_en, pll_en}), 0);
    ie_flag = 1'b1; mask_lvl = 3'd7;
    set_irq(0, 6, 1'b1);
    wake_and_measure(n, kind);
    check(n == 256, "R7 length sel=11 kept from entry", n, 256);
    check(kind == 2, "R8 branch 6<7", kind, 2);
  endtask

  task automatic t_latch_in_stab();
    int n;
    enter_stop(1'b0, 2'b10);
    ie_flag = 1'b1; mask_lvl = 3'd3;
    set_irq(0, 5, 1'b1);
    tick();
    irq_req = '0;
    n = 1;
    repeat (20) begin tick(); n++; end
    set_irq(2, 1, 1'b1);
    tick(); n++;
    irq_req = '0;
    while (stab_busy && n < 100000) begin tick(); n++; end
    n--;
    check(n == 64, "R9 late request does not restart", n, 64);
    tick();
    check(branch_pulse, "R9 late urgent request latched", int'(branch_pulse), 1);
    tick();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_plain_stop_resume();
    t_pll_stop_branch();
    t_mask_edge();
    t_refuse();
    t_weak_ignored_and_stop_idle();
    check(pll_refused, "R4 sticky across stops", int'(pll_refused), 1);
    t_latch_in_stab();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule